// File: doc/BRIEF.md
# Pipelined Sine and Cosine Generator

This block turns an angle word into the sine and cosine of that angle, both as signed fixed-point fractions. It uses shift-and-add vector rotation, with one micro-rotation per pipeline stage. It accepts a new angle on every clock and returns one result pair per clock after a fixed delay. Because both values of one angle arrive in the same cycle, a caller can fill a 2-D rotation matrix in one step.

Any angle over the whole circle is accepted. The two top bits of the angle pick a quadrant. For the two quadrants that lie beyond a quarter turn on either side of zero, the start vector is pre-turned by a quarter turn and the residual angle is reduced to match. Every residual therefore stays inside the range where the iteration converges.

The start vector is loaded with the reciprocal of the accumulated rotation gain, so the outputs come out unit-scaled and no output multiplier is needed. The arctangent constants are a short stored list for the coarse stages. For the fine stages each constant is computed as a scaled power of two, since the arctangent of a small argument is almost equal to the argument.

The block is driven like a processor custom instruction. The caller pulses `ci_start` with an operand, and `ci_done` marks the cycle in which that operand's result is on the result lines.

Top module: `cordic_sincos`

## Requirements
- R1: `ci_angle` is an unsigned fraction of a full turn, where code v means 360·v/65536 degrees. Bits [15:14] select the quadrant (00 = 0°..90°, 01 = 90°..180°, 10 = 180°..270°, 11 = 270°..360°), and every code is valid.
- R2: `ci_sin` and `ci_cos` are signed Q1.15 (value/32768) and give the sine and cosine of the same issued angle. Each is within 8 LSB of the rounded exact value.
- R3: Outputs saturate instead of wrapping. A result at or near +1.0 reads at most 32767 and stays positive, and a result near −1.0 reads at least −32768.
- R4: The result and `ci_done` appear in the cycle that follows the 17th rising edge, counting the edge that samples `ci_start` as the first (STAGES + 2 edges). `ci_done` is high for exactly one cycle per issued operand.
- R5: `ci_start` may be high on every cycle. N consecutive issues give N consecutive `ci_done` cycles, with results in issue order.
- R6: While `ci_done` is low, `ci_sin` and `ci_cos` keep their last values. `ci_angle` is ignored when `ci_start` is low.
- R7: Reset clears every operation in flight, so no `ci_done` appears afterwards for operands issued before reset. Reset also drives `ci_done`, `ci_sin` and `ci_cos` to zero.
- R8: Codes one LSB on either side of each quadrant boundary (0°, 90°, 180°, 270°) meet the R2 accuracy. The internal residual angle never exceeds a quarter turn.
- R9: For every result, sin² + cos² lies between (32768−24)² and (32768+24)².

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ci_start | input | 1 | Issue strobe; samples `ci_angle` on this edge |
| ci_angle | input | 16 | Angle as an unsigned fraction of a full turn |
| ci_done | output | 1 | High in the cycle the issued operand's result is present |
| ci_sin | output | 16 | Sine, signed Q1.15, saturated |
| ci_cos | output | 16 | Cosine, signed Q1.15, saturated |

## Verification
The hardest situation to reach from the ports is a dense, gapless stream in which neighbouring operands sit on opposite sides of a quadrant fold. In that stream, one pipeline stage carries a residual at exactly minus a quarter turn while the next carries one near zero, and a slip in ordering or folding would not show up with isolated issues. The stimulus sends bursts with no idle cycle between issues, using codes one LSB away from every boundary. It then sends a long burst with a stride that walks through all four quadrants. The bench checks the exact cycle of the first `ci_done`, checks that the done train has no gap, and matches each result against its issue slot. A separate sequence resets the block while operands are in flight, to confirm that none of them emerges afterwards.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    // Arctangent constants are expressed in turns scaled by 2^TAB_FRAC.
    localparam int     TAB_FRAC     = 20;
    // 2^TAB_FRAC / (2*pi): converts a radian value to scaled turns.
    localparam longint RAD_TO_TURN  = 166886;
    // Reciprocal of the accumulated rotation gain, scaled by 2^31.
    localparam longint INV_GAIN_Q31 = 1304065748;

    // Arctangent of 2^-idx in turns scaled by 2^frac (frac <= TAB_FRAC).
    // Coarse stages use stored values; fine stages use atan(x) ~= x.
    function automatic longint atan_turns(input int idx, input int frac);
        longint v;
        case (idx)
            0:       v = 131072;
            1:       v = 77377;
            2:       v = 40883;
            3:       v = 20753;
            4:       v = 10417;
            5:       v = 5213;
            6:       v = 2607;
            7:       v = 1304;
            default: v = (RAD_TO_TURN + (longint'(1) << (idx - 1))) >>> idx;
        endcase
        if (frac < TAB_FRAC)
            v = (v + (longint'(1) << (TAB_FRAC - frac - 1))) >>> (TAB_FRAC - frac);
        return v;
    endfunction

    // Start-vector magnitude with frac_bits fractional bits, rounded.
    function automatic longint inv_gain(input int frac_bits);
        return (INV_GAIN_Q31 + (longint'(1) << (30 - frac_bits))) >>> (31 - frac_bits);
    endfunction

endpackage

// File: rtl/cordic_fold.sv
// Maps a full-turn angle into the convergence range by pre-turning the
// start vector a quarter turn for the two outer quadrants.
module cordic_fold #(
    parameter int ANGLE_W = 16,
    parameter int ZG      = 4,
    parameter int DATA_W  = 16,
    parameter int GUARD   = 3,
    parameter int IW      = DATA_W + GUARD + 1,
    parameter int ZW      = ANGLE_W + ZG + 1
) (
    input  logic [ANGLE_W-1:0]   angle_i,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    localparam int AF = ANGLE_W + ZG;
    localparam logic signed [ZW-1:0] QTR    = ZW'(longint'(1) << (AF - 2));
    localparam logic signed [IW-1:0] X_INIT = IW'(cordic_pkg::inv_gain(DATA_W - 1 + GUARD));

    logic [1:0]           quad;
    logic signed [ZW-1:0] a_s;

    always_comb begin
        quad = angle_i[ANGLE_W-1 -: 2];
        a_s  = ZW'($signed({angle_i, {ZG{1'b0}}}));
        case (quad)
            2'b01: begin
                x_o = '0;
                y_o = X_INIT;
                z_o = a_s - QTR;
            end
            2'b10: begin
                x_o = '0;
                y_o = -X_INIT;
                z_o = a_s + QTR;
            end
            default: begin
                x_o = X_INIT;
                y_o = '0;
                z_o = a_s;
            end
        endcase
    end

endmodule

// File: rtl/cordic_stage.sv
// One registered micro-rotation.
module cordic_stage #(
    parameter int IW    = 20,
    parameter int ZW    = 21,
    parameter int SHIFT = 0,
    parameter logic signed [ZW-1:0] ATAN = '0,
    parameter logic signed [ZW-1:0] ZLIM = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_i,
    input  logic signed [IW-1:0] x_i,
    input  logic signed [IW-1:0] y_i,
    input  logic signed [ZW-1:0] z_i,
    output logic                 vld_o,
    output logic signed [IW-1:0] x_o,
    output logic signed [IW-1:0] y_o,
    output logic signed [ZW-1:0] z_o
);
    typedef struct packed {
        logic                 vld;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [ZW-1:0] z;
    } stage_t;

    stage_t               st_d, st_q;
    logic signed [IW-1:0] xs, ys;

    always_comb begin
        xs     = x_i >>> SHIFT;
        ys     = y_i >>> SHIFT;
        st_d.vld = vld_i;
        if (z_i >= 0) begin
            st_d.x = x_i - ys;
            st_d.y = y_i + xs;
            st_d.z = z_i - ATAN;
        end else begin
            st_d.x = x_i + ys;
            st_d.y = y_i - xs;
            st_d.z = z_i + ATAN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o = st_q.vld;
    assign x_o   = st_q.x;
    assign y_o   = st_q.y;
    assign z_o   = st_q.z;

    // R8: the residual angle never leaves the quarter-turn window
    a_r8_residual_quarter: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> (st_q.z <= ZLIM && st_q.z >= -ZLIM));

endmodule

// File: rtl/cordic_sat.sv
// Drops guard bits with rounding and clamps to the output word.
module cordic_sat #(
    parameter int IW     = 20,
    parameter int DATA_W = 16,
    parameter int GUARD  = 3
) (
    input  logic signed [IW-1:0]     val_i,
    output logic signed [DATA_W-1:0] val_o
);
    localparam logic signed [IW:0] RND  = (IW+1)'(longint'(1) << (GUARD - 1));
    localparam logic signed [IW:0] MAXV = (IW+1)'((longint'(1) << (DATA_W - 1)) - 1);
    localparam logic signed [IW:0] MINV = -MAXV - (IW+1)'(1);

    logic signed [IW:0] rounded, sh;

    always_comb begin
        rounded = (IW+1)'(val_i) + RND;
        sh      = rounded >>> GUARD;
        if (sh > MAXV)      val_o = MAXV[DATA_W-1:0];
        else if (sh < MINV) val_o = MINV[DATA_W-1:0];
        else                val_o = sh[DATA_W-1:0];
    end

endmodule

// File: rtl/cordic_sincos.sv
module cordic_sincos #(
    parameter int ANGLE_W = 16,
    parameter int DATA_W  = 16,
    parameter int STAGES  = 15,
    parameter int GUARD   = 3,
    parameter int ZG      = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ci_start,
    input  logic [ANGLE_W-1:0]       ci_angle,
    output logic                     ci_done,
    output logic signed [DATA_W-1:0] ci_sin,
    output logic signed [DATA_W-1:0] ci_cos
);
    localparam int IW  = DATA_W + GUARD + 1;
    localparam int AF  = ANGLE_W + ZG;
    localparam int ZW  = AF + 1;
    localparam int LAT = STAGES + 2;
    localparam logic signed [ZW-1:0] QTR  = ZW'(longint'(1) << (AF - 2));
    localparam logic signed [ZW-1:0] ZEND = ZW'(2 * cordic_pkg::atan_turns(STAGES - 1, AF));

    typedef struct packed {
        logic                 vld;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic signed [ZW-1:0] z;
    } entry_t;

    typedef struct packed {
        logic                     done;
        logic signed [DATA_W-1:0] sn;
        logic signed [DATA_W-1:0] cs;
    } result_t;

    entry_t  ent_d, ent_q;
    result_t out_d, out_q;

    logic signed [IW-1:0]     fx, fy;
    logic signed [ZW-1:0]     fz;
    logic signed [DATA_W-1:0] sat_sin, sat_cos;

    logic                 v_pipe [0:STAGES];
    logic signed [IW-1:0] x_pipe [0:STAGES];
    logic signed [IW-1:0] y_pipe [0:STAGES];
    logic signed [ZW-1:0] z_pipe [0:STAGES];

    cordic_fold #(
        .ANGLE_W(ANGLE_W), .ZG(ZG), .DATA_W(DATA_W), .GUARD(GUARD), .IW(IW), .ZW(ZW)
    ) u_fold (
        .angle_i(ci_angle), .x_o(fx), .y_o(fy), .z_o(fz)
    );

    always_comb begin
        ent_d.vld = ci_start;
        ent_d.x   = fx;
        ent_d.y   = fy;
        ent_d.z   = fz;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q <= '0;
        else        ent_q <= ent_d;
    end

    assign v_pipe[0] = ent_q.vld;
    assign x_pipe[0] = ent_q.x;
    assign y_pipe[0] = ent_q.y;
    assign z_pipe[0] = ent_q.z;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        localparam logic signed [ZW-1:0] AT = ZW'(cordic_pkg::atan_turns(g, AF));
        cordic_stage #(
            .IW(IW), .ZW(ZW), .SHIFT(g), .ATAN(AT), .ZLIM(QTR)
        ) u_stage (
            .clk(clk), .rst_n(rst_n),
            .vld_i(v_pipe[g]),   .x_i(x_pipe[g]),   .y_i(y_pipe[g]),   .z_i(z_pipe[g]),
            .vld_o(v_pipe[g+1]), .x_o(x_pipe[g+1]), .y_o(y_pipe[g+1]), .z_o(z_pipe[g+1])
        );
    end

    cordic_sat #(.IW(IW), .DATA_W(DATA_W), .GUARD(GUARD)) u_sat_cos (
        .val_i(x_pipe[STAGES]), .val_o(sat_cos)
    );
    cordic_sat #(.IW(IW), .DATA_W(DATA_W), .GUARD(GUARD)) u_sat_sin (
        .val_i(y_pipe[STAGES]), .val_o(sat_sin)
    );

    always_comb begin
        out_d      = out_q;
        out_d.done = v_pipe[STAGES];
        if (v_pipe[STAGES]) begin
            out_d.sn = sat_sin;
            out_d.cs = sat_cos;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign ci_done = out_q.done;
    assign ci_sin  = out_q.sn;
    assign ci_cos  = out_q.cs;

    // ---------------- assertions ----------------
    localparam int     CW      = $clog2(LAT + 2) + 1;
    localparam longint ONE_Q   = longint'(1) << (DATA_W - 1);
    localparam longint NORM_LO = (ONE_Q - 24) * (ONE_Q - 24);
    localparam longint NORM_HI = (ONE_Q + 24) * (ONE_Q + 24);

    logic [CW-1:0] inflight_q;
    longint        norm_sq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight_q <= '0;
        else        inflight_q <= inflight_q + CW'(ci_start) - CW'(ci_done);
    end

    always_comb norm_sq = longint'(ci_sin) * longint'(ci_sin) + longint'(ci_cos) * longint'(ci_cos);

    // R9: every delivered pair lies on the unit circle
    a_r9_unit_norm: assert property (@(posedge clk) disable iff (!rst_n)
        ci_done |-> (norm_sq >= NORM_LO && norm_sq <= NORM_HI));

    // R6: results hold while no operand completes
    a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !ci_done |-> ($stable(ci_sin) && $stable(ci_cos)));

    // R4: a completion always belongs to an earlier issue
    a_r4_done_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
        ci_done |-> (inflight_q != '0));

    // R5: never more operands in flight than pipeline slots
    a_r5_inflight_bound: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= CW'(LAT));

    // R2: the residual angle has converged at the last stage
    a_r2_residual_converged: assert property (@(posedge clk) disable iff (!rst_n)
        v_pipe[STAGES] |-> (z_pipe[STAGES] <= ZEND && z_pipe[STAGES] >= -ZEND));

endmodule

// File: tb/cordic_sincos_tb.sv
module cordic_sincos_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int ST  = 15;
    localparam int LAT = ST + 2;
    localparam int TOL = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 ci_start = 1'b0;
    logic [AW-1:0]        ci_angle = '0;
    logic                 ci_done;
    logic signed [DW-1:0] ci_sin, ci_cos;

    int n_checks = 0;
    int n_fail   = 0;

    logic [AW-1:0] batch   [64];
    int            res_sin [64];
    int            res_cos [64];
    int            batch_n = 0;
    int            first_done;
    int            got;

    always #(CLK_PERIOD/2) clk = ~clk;

    cordic_sincos u_dut (
        .clk(clk), .rst_n(rst_n), .ci_start(ci_start), .ci_angle(ci_angle),
        .ci_done(ci_done), .ci_sin(ci_sin), .ci_cos(ci_cos)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ref_val(input logic [AW-1:0] a, input bit want_sin);
        real ph, r;
        int  v;
        ph = 2.0 * 3.14159265358979 * real'(int'(a)) / real'(1 << AW);
        r  = (want_sin ? $sin(ph) : $cos(ph)) * 32768.0;
        v  = $rtoi(r >= 0.0 ? r + 0.5 : r - 0.5);
        if (v > 32767)  v = 32767;
        if (v < -32768) v = -32768;
        return v;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Issues batch[0..batch_n-1] on consecutive cycles and collects results.
    task automatic run_batch(input string req);
        int  done_cnt;
        bit  gap;
        bit  seen_end;
        int  es, ec;
        longint nrm;
        got = 0; first_done = -1; done_cnt = 0; gap = 0; seen_end = 0;
        for (int cyc = 0; cyc < batch_n + LAT + 3; cyc++) begin
            @(negedge clk);
            if (ci_done === 1'b1) begin
                if (first_done < 0) first_done = cyc;
                if (seen_end) gap = 1;
                done_cnt++;
                if (got < batch_n) begin
                    res_sin[got] = int'(ci_sin);
                    res_cos[got] = int'(ci_cos);
                    es = ref_val(batch[got], 1'b1);
                    ec = ref_val(batch[got], 1'b0);
                    check(iabs(int'(ci_sin) - es) <= TOL, req,
                          $sformatf("sin angle=%0h", batch[got]), ci_sin, es);
                    check(iabs(int'(ci_cos) - ec) <= TOL, req,
                          $sformatf("cos angle=%0h", batch[got]), ci_cos, ec);
                    nrm = longint'(ci_sin) * ci_sin + longint'(ci_cos) * ci_cos;
                    check(nrm >= longint'(32744) * 32744 && nrm <= longint'(32792) * 32792,
                          "R9", $sformatf("norm angle=%0h", batch[got]), nrm, longint'(1) << 30);
                end
                got++;
            end else if (first_done >= 0) begin
                seen_end = 1;
            end
            if (cyc < batch_n) begin
                ci_start = 1'b1;
                ci_angle = batch[cyc];
            end else begin
                ci_start = 1'b0;
            end
        end
        check(first_done == LAT, "R4", "first done cycle", first_done, LAT);
        check(done_cnt == batch_n && !gap, "R5", "done train length", done_cnt, batch_n);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check(ci_done === 1'b0, "R7", "done in reset", ci_done, 0);
        check(ci_sin === '0 && ci_cos === '0, "R7", "results in reset", ci_sin, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_quadrants();
        batch[0] = 16'h0000; batch[1] = 16'h4000; batch[2] = 16'h8000; batch[3] = 16'hC000;
        batch[4] = 16'h2000; batch[5] = 16'h6000; batch[6] = 16'hA000; batch[7] = 16'hE000;
        batch_n = 8;
        run_batch("R1");
    endtask

    task automatic t_saturation();
        // R3: results from the quadrant batch at 0 deg, 90 deg and 180 deg
        check(res_cos[0] >= 32760 && res_cos[0] <= 32767, "R3", "cos(0) clamp", res_cos[0], 32767);
        check(res_sin[1] >= 32760 && res_sin[1] <= 32767, "R3", "sin(90) clamp", res_sin[1], 32767);
        check(res_cos[2] <= -32760 && res_cos[2] >= -32768, "R3", "cos(180) clamp", res_cos[2], -32768);
        check(res_sin[3] <= -32760 && res_sin[3] >= -32768, "R3", "sin(270) clamp", res_sin[3], -32768);
    endtask

    task automatic t_boundaries();
        batch[0] = 16'hFFFF; batch[1] = 16'h0001; batch[2] = 16'h3FFF; batch[3] = 16'h4001;
        batch[4] = 16'h7FFF; batch[5] = 16'h8001; batch[6] = 16'hBFFF; batch[7] = 16'hC001;
        batch_n = 8;
        run_batch("R8");
    endtask

    task automatic t_stream();
        for (int i = 0; i < 64; i++) batch[i] = AW'(i * 1031 + 77);
        batch_n = 64;
        run_batch("R2");
    endtask

    task automatic t_hold();
        int  ls, lc;
        bit  ok;
        ls = int'(ci_sin); lc = int'(ci_cos); ok = 1;
        for (int i = 0; i < 12; i++) begin
            ci_start = 1'b0;
            ci_angle = AW'(i * 5003);
            @(negedge clk);
            if (ci_done !== 1'b0 || int'(ci_sin) != ls || int'(ci_cos) != lc) ok = 0;
        end
        check(ok, "R6", "results held with start low", ci_sin, ls);
    endtask

    task automatic t_reset_flush();
        bit any_done;
        any_done = 0;
        for (int i = 0; i < 5; i++) begin
            ci_start = 1'b1;
            ci_angle = AW'(i * 3000 + 100);
            @(negedge clk);
        end
        ci_start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(ci_sin === '0 && ci_cos === '0, "R7", "results cleared", ci_sin, 0);
        rst_n = 1'b1;
        for (int i = 0; i < LAT + 8; i++) begin
            @(negedge clk);
            if (ci_done === 1'b1) any_done = 1;
        end
        check(!any_done, "R7", "no done after reset", any_done, 0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        t_reset_state();
        t_quadrants();
        t_saturation();
        t_hold();
        t_boundaries();
        t_stream();
        t_reset_flush();
        summary();
        $finish;
    end

endmodule